// File: doc/BRIEF.md
# Narrow-Port Access Splitter

This block connects an internal bus master to an external memory port set up as an 8-bit access space. The master issues one read or write request with an address and a transfer size of one, two or four bytes. The block turns that request into a run of single-byte external cycles. Each cycle uses a request/acknowledge handshake. The byte always travels on one half of a 16-bit external data bus.

The half that is used depends on the bus mode, which is captured when the request is accepted. In normal mode the byte uses the upper lane. In address/data multiplexed mode it uses the lower lane. Multi-byte transfers go out most significant byte first, at consecutive addresses. For reads, the returned bytes are packed into a zero-extended 32-bit result, and a one-cycle completion pulse marks the end of the transfer.

Top module: `nps_splitter`

## Requirements
- R1: A request is accepted only on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle in which `done` pulses. Requests presented while `busy` is high have no effect.
- R2: The size code sets the number of external byte cycles: 2'b00 gives one, 2'b01 gives two, 2'b10 gives four, and 2'b11 is handled as a single byte.
- R3: Bytes are transferred most significant first. A four-byte write sends bits 31:24, 23:16, 15:8 and then 7:0. A two-byte write sends 15:8 and then 7:0. A one-byte write sends 7:0.
- R4: `ext_addr` equals the request address for the first byte cycle. It increases by one, modulo 2^AW, after each acknowledged byte that is not the last one.
- R5: `ext_req` is high while `busy` is high. `ext_addr` and `ext_we` hold their values until `ext_ack` is sampled high, and only then does the block move to the next byte.
- R6: When `mux_mode` is 0 at acceptance, bytes are driven on and sampled from `ext_wdata`/`ext_rdata` bits 15:8. When it is 1, bits 7:0 are used. Changes of `mux_mode` during a transfer have no effect.
- R7: During write cycles, the lane not in use carries zero and only the output enable of the active lane (`ext_oe_hi` for bits 15:8, `ext_oe_lo` for bits 7:0) is high. Both enables and all of `ext_wdata` are zero during reads and when idle.
- R8: For a read, `rdata` holds the returned bytes with the first byte in the most significant used position, zero-extended to 32 bits. It is updated in the cycle `done` pulses and is unchanged by writes.
- R9: `done` is a one-cycle pulse in the cycle after the final acknowledge, and `busy` falls in that same cycle.
- R10: After reset, `busy`, `done`, `ext_req`, `ext_we`, both output enables, `ext_wdata` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code (00 byte, 01 two bytes, 10 four bytes, 11 byte) |
| req_addr | input | AW | Start byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| mux_mode | input | 1 | 0 = normal (upper lane), 1 = multiplexed (lower lane) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read result |
| ext_req | output | 1 | External byte cycle request |
| ext_we | output | 1 | External cycle is a write |
| ext_addr | output | AW | External byte address |
| ext_wdata | output | 16 | External write data, both lanes |
| ext_oe_hi | output | 1 | Drive enable for bits 15:8 |
| ext_oe_lo | output | 1 | Drive enable for bits 7:0 |
| ext_ack | input | 1 | External byte cycle acknowledge |
| ext_rdata | input | 16 | External read data, both lanes |

## Verification
The bench's external responder puts different byte values on the two lanes. A design that samples or drives the wrong half therefore produces a visibly wrong result, and so does one that reverses byte order or fails to zero-extend short reads. Tests include acknowledges held high for consecutive cycles and acknowledges delayed by several cycles, which expose a design that advances without a handshake or skips bytes. Tests also include an address that wraps past the top of the space, a request held high throughout a busy transfer, and a mode flip in the middle of a transfer. A design that accepts a second request, or re-steers lanes part way through a transfer, would fail these. The reserved size code and back-to-back transfers started in the cycle right after completion are also covered.

// File: rtl/nps_pkg.sv
package nps_pkg;

    localparam int WORD_W    = 32;
    localparam int BUS_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int LANES     = BUS_W / BYTE_W;
    localparam int BEATS_MAX = WORD_W / BYTE_W;
    localparam int CNT_W     = $clog2(BEATS_MAX + 1);
    localparam int LANE_HI   = LANES - 1;
    localparam int LANE_LO   = 0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_FULL = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic we;
        logic mux;
    } xfer_ctl_t;

    // number of external byte cycles for a size code
    function automatic logic [CNT_W-1:0] beats_of(xfer_size_e s);
        case (s)
            SZ_HALF: return CNT_W'(2);
            SZ_FULL: return CNT_W'(BEATS_MAX);
            default: return CNT_W'(1);
        endcase
    endfunction

    // move the most significant used byte of the write data to the top
    function automatic logic [WORD_W-1:0] align_msb(xfer_size_e s, logic [WORD_W-1:0] d);
        int unsigned sh;
        sh = WORD_W - BYTE_W * int'(beats_of(s));
        return d << sh;
    endfunction

    // one-hot lane selection: upper lane in normal mode, lower in mux mode
    function automatic logic [LANES-1:0] lane_sel(logic mux);
        logic [LANES-1:0] r;
        r = '0;
        if (mux) r[LANE_LO] = 1'b1;
        else     r[LANE_HI] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/nps_seq.sv
module nps_seq
    import nps_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  xfer_size_e    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic          mux_mode,
    input  logic          ext_ack,
    output logic          busy,
    output logic          accept,
    output logic          step,
    output logic          last,
    output logic          done,
    output xfer_ctl_t     ctl,
    output logic [AW-1:0] addr
);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] left_q;
    logic [AW-1:0]    addr_q;
    xfer_ctl_t        ctl_q;

    assign accept = req_valid & ~busy_q;
    assign step   = busy_q & ext_ack;
    assign last   = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            left_q <= '0;
            addr_q <= '0;
            ctl_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q    <= 1'b1;
                left_q    <= beats_of(req_size);
                addr_q    <= req_addr;
                ctl_q.we  <= req_write;
                ctl_q.mux <= mux_mode;
            end else if (step) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    left_q <= '0;
                end else begin
                    left_q <= left_q - CNT_W'(1);
                    addr_q <= addr_q + AW'(1);
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign ctl  = ctl_q;
    assign addr = addr_q;

endmodule

// File: rtl/nps_datapath.sv
module nps_datapath
    import nps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              step,
    input  logic              last,
    input  logic              capture,
    input  xfer_size_e        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] wr_byte,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] wsh_q;
    logic [WORD_W-1:0] rsh_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] rsh_next;

    assign rsh_next = {rsh_q[WORD_W-BYTE_W-1:0], rd_byte};

    always_ff @(posedge clk) begin
        if (rst) begin
            wsh_q   <= '0;
            rsh_q   <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            wsh_q <= align_msb(req_size, req_wdata);
            rsh_q <= '0;
        end else if (step) begin
            wsh_q <= wsh_q << BYTE_W;
            rsh_q <= rsh_next;
            if (last && capture) rdata_q <= rsh_next;
        end
    end

    assign wr_byte = wsh_q[WORD_W-1 -: BYTE_W];
    assign rdata   = rdata_q;

endmodule

// File: rtl/nps_lane.sv
module nps_lane
    import nps_pkg::*;
(
    input  logic              sel,
    input  logic              busy,
    input  xfer_ctl_t         ctl,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [BYTE_W-1:0] bus_rd,
    output logic [BYTE_W-1:0] bus_wd,
    output logic              oe,
    output logic [BYTE_W-1:0] rd_masked
);

    logic drive;

    assign drive     = busy & ctl.we & sel;
    assign oe        = drive;
    assign bus_wd    = drive ? wr_byte : '0;
    assign rd_masked = sel ? bus_rd : '0;

endmodule

// File: rtl/nps_splitter.sv
module nps_splitter
    import nps_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              mux_mode,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              ext_req,
    output logic              ext_we,
    output logic [AW-1:0]     ext_addr,
    output logic [BUS_W-1:0]  ext_wdata,
    output logic              ext_oe_hi,
    output logic              ext_oe_lo,
    input  logic              ext_ack,
    input  logic [BUS_W-1:0]  ext_rdata
);

    xfer_size_e                     size_e;
    logic                           accept;
    logic                           step;
    logic                           last;
    logic                           busy_w;
    xfer_ctl_t                      ctl;
    logic [BYTE_W-1:0]              wr_byte;
    logic [BYTE_W-1:0]              rd_byte;
    logic [LANES-1:0]               sel;
    logic [LANES-1:0]               lane_oe;
    logic [LANES-1:0][BYTE_W-1:0]   rd_mask;

    assign size_e = xfer_size_e'(req_size);
    assign sel    = lane_sel(ctl.mux);

    nps_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (size_e),
        .req_addr  (req_addr),
        .mux_mode  (mux_mode),
        .ext_ack   (ext_ack),
        .busy      (busy_w),
        .accept    (accept),
        .step      (step),
        .last      (last),
        .done      (done),
        .ctl       (ctl),
        .addr      (ext_addr)
    );

    nps_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .step      (step),
        .last      (last),
        .capture   (~ctl.we),
        .req_size  (size_e),
        .req_wdata (req_wdata),
        .rd_byte   (rd_byte),
        .wr_byte   (wr_byte),
        .rdata     (rdata)
    );

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        nps_lane u_lane (
            .sel       (sel[gi]),
            .busy      (busy_w),
            .ctl       (ctl),
            .wr_byte   (wr_byte),
            .bus_rd    (ext_rdata[gi*BYTE_W +: BYTE_W]),
            .bus_wd    (ext_wdata[gi*BYTE_W +: BYTE_W]),
            .oe        (lane_oe[gi]),
            .rd_masked (rd_mask[gi])
        );
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < LANES; i++) rd_byte |= rd_mask[i];
    end

    assign busy      = busy_w;
    assign ext_req   = busy_w;
    assign ext_we    = busy_w & ctl.we;
    assign ext_oe_hi = lane_oe[LANE_HI];
    assign ext_oe_lo = lane_oe[LANE_LO];

endmodule

// File: rtl/nps_splitter_chk.sv
module nps_splitter_chk
    import nps_pkg::*;
#(
    parameter int AW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              ext_req,
    input logic              ext_we,
    input logic [AW-1:0]     ext_addr,
    input logic [BUS_W-1:0]  ext_wdata,
    input logic              ext_oe_hi,
    input logic              ext_oe_lo,
    input logic              ext_ack
);

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !ext_ack) |=> (busy && ext_req && $stable(ext_addr) && $stable(ext_we)));

    p_incr_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && ext_ack) |=> (done || (ext_addr == $past(ext_addr) + 1'b1)));

    p_one_lane_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_oe_hi, ext_oe_lo}));

    p_oe_write_r7: assert property (@(posedge clk) disable iff (rst)
        (ext_oe_hi || ext_oe_lo) |-> (ext_req && ext_we));

    p_idle_hi_r7: assert property (@(posedge clk) disable iff (rst)
        !ext_oe_hi |-> (ext_wdata[BUS_W-1 -: BYTE_W] == '0));

    p_idle_lo_r7: assert property (@(posedge clk) disable iff (rst)
        !ext_oe_lo |-> (ext_wdata[BYTE_W-1:0] == '0));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind nps_splitter nps_splitter_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_oe_hi (ext_oe_hi),
    .ext_oe_lo (ext_oe_lo),
    .ext_ack   (ext_ack)
);

// File: tb/tb_nps_splitter.sv
`timescale 1ns/1ps
module tb_nps_splitter;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          mux_mode = 1'b0;
    logic          busy, done;
    logic [31:0]   rdata;
    logic          ext_req, ext_we, ext_oe_hi, ext_oe_lo;
    logic [AW-1:0] ext_addr;
    logic [15:0]   ext_wdata;
    logic          ext_ack = 1'b0;
    logic [15:0]   ext_rdata = '0;

    always #2 clk = ~clk;

    nps_splitter #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .mux_mode(mux_mode), .busy(busy), .done(done), .rdata(rdata),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_oe_hi(ext_oe_hi), .ext_oe_lo(ext_oe_lo),
        .ext_ack(ext_ack), .ext_rdata(ext_rdata)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit started = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int beats(input logic [1:0] s);
        return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
    endfunction
    function automatic logic [7:0] hi_b(input logic [15:0] a);
        return a[7:0] ^ 8'hA5 ^ a[15:8];
    endfunction
    function automatic logic [7:0] lo_b(input logic [15:0] a);
        return (a[7:0] + 8'h11) ^ 8'h3C;
    endfunction

    // ---------------- external responder ----------------
    int slave_wait = 0;
    int wcnt = 0;
    int acks_seen = 0;
    bit cur_mux = 0;
    logic [7:0] cap_q[$];

    always @(negedge clk) begin
        if (rst) begin
            ext_ack = 1'b0;
            wcnt = 0;
        end else if (slave_wait < 0) begin
            ext_ack = ext_req;
        end else if (ext_ack) begin
            ext_ack = 1'b0;
            wcnt = 0;
        end else if (ext_req) begin
            if (wcnt >= slave_wait) ext_ack = 1'b1;
            else wcnt++;
        end
        if (ext_ack) begin
            ext_rdata = {hi_b(ext_addr), lo_b(ext_addr)};
            acks_seen++;
            cap_q.push_back(cur_mux ? ext_wdata[7:0] : ext_wdata[15:8]);
        end else begin
            ext_rdata = 16'h0;
        end
    end

    // ---------------- behavioural reference model ----------------
    bit          m_busy, m_done, m_we, m_mux;
    int          m_left;
    logic [15:0] m_addr;
    logic [31:0] m_acc, m_rdata;
    logic [7:0]  m_wq[$];

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_we = 0; m_mux = 0; m_left = 0;
            m_addr = 0; m_acc = 0; m_rdata = 0; m_wq.delete();
            started = 1;
        end else begin
            m_done = 0;
            if (!m_busy && req_valid) begin
                m_busy = 1; m_we = req_write; m_mux = mux_mode;
                m_left = beats(req_size); m_addr = req_addr; m_acc = 0;
                m_wq.delete();
                for (int k = m_left - 1; k >= 0; k--) m_wq.push_back(req_wdata[8*k +: 8]);
            end else if (m_busy && ext_ack) begin
                m_acc = (m_acc << 8) | {24'h0, (m_mux ? ext_rdata[7:0] : ext_rdata[15:8])};
                if (m_wq.size() > 0) void'(m_wq.pop_front());
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1;
                    if (!m_we) m_rdata = m_acc;
                end else begin
                    m_addr = m_addr + 16'd1;
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (started && !rst) begin
            logic [7:0] b;
            b = (m_wq.size() > 0) ? m_wq[0] : 8'h00;
            check(busy == m_busy, "R1", "busy", 32'(busy), 32'(m_busy));
            check(ext_req == m_busy, "R5", "ext_req", 32'(ext_req), 32'(m_busy));
            check(ext_we == (m_busy && m_we), "R5", "ext_we", 32'(ext_we), 32'(m_busy && m_we));
            if (m_busy) check(ext_addr == m_addr, "R4", "ext_addr", 32'(ext_addr), 32'(m_addr));
            check(ext_wdata == ((m_busy && m_we) ? (m_mux ? {8'h0, b} : {b, 8'h0}) : 16'h0),
                  "R6", "ext_wdata", 32'(ext_wdata),
                  32'((m_busy && m_we) ? (m_mux ? {8'h0, b} : {b, 8'h0}) : 16'h0));
            check(ext_oe_hi == (m_busy && m_we && !m_mux), "R7", "ext_oe_hi",
                  32'(ext_oe_hi), 32'(m_busy && m_we && !m_mux));
            check(ext_oe_lo == (m_busy && m_we && m_mux), "R7", "ext_oe_lo",
                  32'(ext_oe_lo), 32'(m_busy && m_we && m_mux));
            check(done == m_done, "R9", "done", 32'(done), 32'(m_done));
            check(rdata == m_rdata, "R8", "rdata", rdata, m_rdata);
        end
    end

    // ---------------- directed transfers ----------------
    task automatic xfer(input bit we, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] d, input bit mux, input int wt,
                        input bit junk, input bit flip);
        int n;
        int guard;
        logic [31:0] exp;
        logic [15:0] ak;
        n = beats(sz);
        slave_wait = wt;
        cur_mux = mux;
        acks_seen = 0;
        cap_q.delete();
        req_valid = 1; req_write = we; req_size = sz; req_addr = a;
        req_wdata = d; mux_mode = mux;
        @(negedge clk);
        if (junk) begin
            req_write = ~we; req_size = 2'b10; req_addr = a ^ 16'h0F0F;
            req_wdata = ~d; mux_mode = ~mux;
        end else begin
            req_valid = 0;
        end
        guard = 0;
        while (!done && guard < 200) begin
            if (flip) mux_mode = ~mux_mode;
            @(negedge clk);
            guard++;
        end
        req_valid = 0;
        mux_mode = mux;
        check(done, "R9", "done seen", 32'(done), 32'd1);
        check(acks_seen == n, "R2", "byte cycles", 32'(acks_seen), 32'(n));
        if (we) begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] got;
                got = (k < cap_q.size()) ? cap_q[k] : 8'hXX;
                check(got === d[8*(n-1-k) +: 8], "R3", "write byte order",
                      32'(got), 32'(d[8*(n-1-k) +: 8]));
            end
        end else begin
            exp = 0;
            for (int k = 0; k < n; k++) begin
                ak = a + 16'(k);
                exp = (exp << 8) | {24'h0, (mux ? lo_b(ak) : hi_b(ak))};
            end
            check(rdata == exp, "R8", "read result", rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        check({busy, done, ext_req, ext_we, ext_oe_hi, ext_oe_lo} == 6'b0, "R10", "ctrl after reset",
              32'({busy, done, ext_req, ext_we, ext_oe_hi, ext_oe_lo}), 32'd0);
        check(ext_wdata == 16'h0 && rdata == 32'h0, "R10", "data after reset",
              {ext_wdata, rdata[15:0]}, 32'd0);
        @(negedge clk);
        xfer(0, 2'b00, 16'h0040, 32'h0, 0, 0, 0, 0);                  // R2 byte read normal
        xfer(0, 2'b01, 16'h1234, 32'h0, 0, 1, 0, 0);                  // R3 word read
        xfer(0, 2'b10, 16'h2000, 32'h0, 0, 0, 0, 0);                  // long read normal
        xfer(0, 2'b10, 16'h2000, 32'h0, 1, 2, 0, 0);                  // R6 long read mux
        xfer(1, 2'b01, 16'h0100, 32'hFFFF_BEEF, 0, 0, 0, 0);          // word write normal
        xfer(1, 2'b10, 16'h0300, 32'h1122_3344, 1, -1, 0, 0);         // R5 long write, ack held
        xfer(1, 2'b00, 16'h0007, 32'hAAAA_AA5C, 1, 1, 0, 0);          // byte write mux
        xfer(0, 2'b11, 16'h0055, 32'h0, 0, 0, 0, 0);                  // R2 reserved code
        xfer(0, 2'b10, 16'hFFFE, 32'h0, 1, 3, 0, 0);                  // R4 address wrap
        xfer(1, 2'b10, 16'h0A00, 32'hDEAD_C0DE, 0, 1, 1, 0);          // R1 junk while busy
        xfer(0, 2'b10, 16'h0B00, 32'h0, 0, -1, 1, 1);                 // R6 mode flip mid-transfer
        xfer(1, 2'b10, 16'h0C00, 32'h0102_0304, 1, 2, 0, 1);          // write with flip
        xfer(0, 2'b01, 16'h0D10, 32'h0, 1, -1, 0, 0);                 // back-to-back next
        xfer(1, 2'b00, 16'h0D20, 32'h0000_0081, 0, -1, 0, 0);         // R8 rdata unchanged by write
        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule